// File: doc/BRIEF.md
# Redirecting Paged Read Sequencer

This block answers an extended-read request to a write-once memory of 64 pages of 32 bytes each. An upstream byte transport delivers a command byte and two address bytes. After that, each request strobe pulls one response byte out of the block. Before the data of each page, the block reports that page's redirection byte and a CRC-16. The data bytes of the page follow, and then a second CRC-16 that covers only those data bytes. The block then moves to the next page, and this continues through the last page. After the last page, every further request returns all-ones.

A redirection byte of FFh marks a page that is still valid. Any other value holds the ones' complement of the page that replaces it. The block only passes this byte on; it does not act on it, so reading always continues with the next physical page. The data array and the redirection table are inside the block and are filled through a plain load port. One CRC-16 generator is shared by all phases, and the sequencer clears or loads it as each phase requires.

Top module: `paged_redirect_reader`

## Requirements
- R1: After the asynchronous reset `rst_ni` or a cycle with the synchronous `abort_i` high, the block waits for a command byte, drives `rsp_valid_o` low, and discards any partly received address.
- R2: Only the command byte A5h starts a transaction. A command byte with any other value is ignored and leaves no trace in the CRC.
- R3: The address arrives as a low byte and then a high byte. The 16-bit value is masked to 11 bits; bits [10:5] select the page and bits [4:0] select the byte within the page. The CRC still covers the address bytes exactly as received.
- R4: The first response byte is the redirection byte of the starting page. It is followed by the CRC-16, computed from a cleared generator over A5h, the low address byte, the high address byte and the redirection byte. The CRC uses polynomial x^16+x^15+x^2+1, shifts each byte in LSB first, and is sent inverted, low byte first.
- R5: After that CRC, the data bytes run from the start address to the end of the current page. They are followed by the inverted CRC-16 of those data bytes alone, computed from a cleared generator.
- R6: On each later page the block sends the redirection byte, then the inverted CRC-16 of that redirection byte alone (from a cleared generator), then all 32 data bytes, then their inverted CRC-16.
- R7: After the CRC of page 63, every further requested byte is FFh until reset or abort.
- R8: A redirection byte other than FFh is reported unchanged and does not alter the order of pages or bytes.
- R9: Each request in a response phase gives exactly one byte with `rsp_valid_o` high on the following cycle. Requests made while the block is waiting for command or address bytes give no response.
- R10: A write through the load port with `ld_sel_i`=0 stores `ld_data_i` at data byte `ld_addr_i`. With `ld_sel_i`=1 it stores `ld_data_i` as the redirection byte of page `ld_addr_i[5:0]`. Later reads return the loaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| abort_i | input | 1 | Synchronous transaction abort |
| cmd_valid_i | input | 1 | Command or address byte present |
| cmd_byte_i | input | 8 | Command or address byte |
| rd_req_i | input | 1 | Request for the next response byte |
| rsp_valid_o | output | 1 | Response byte valid, one cycle after the request |
| rsp_byte_o | output | 8 | Response byte |
| ld_en_i | input | 1 | Load port write enable |
| ld_sel_i | input | 1 | Load target: 0 data array, 1 redirection table |
| ld_addr_i | input | 11 | Load byte address, or page index in bits [5:0] |
| ld_data_i | input | 8 | Load data |

## Verification
A wrong phase state or page-end decision puts a CRC byte where data belongs, or the reverse. This shows up in the very next response byte, and every CRC that follows is then off as well. A CRC generator that is not cleared, or is cleared at the wrong time, changes the next CRC pair to leave the block. A missed first-pass seed shows up only in the first pair, and a missed later-page clear shows up in the pair right after the next redirection byte. An address masked wrongly shows up in the first redirection byte or the first data byte. An end-of-memory fault shows up either in the all-ones bytes after page 63 or in a stray wrap back to page 0.

// File: rtl/prs_pkg.sv
package prs_pkg;
  localparam logic [7:0] CMD_XREAD = 8'hA5;

  typedef enum logic [3:0] {
    ST_CMD, ST_AL, ST_AH, ST_RDIR, ST_RCRC_L, ST_RCRC_H,
    ST_DATA, ST_DCRC_L, ST_DCRC_H, ST_DONE
  } seq_st_e;

  // reflected x^16+x^15+x^2+1, lsb first
  function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ b[i]) r = (r >> 1) ^ 16'hA001;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/prs_crc16.sv
module prs_crc16 (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        upd_i,
  input  logic [7:0]  din_i,
  output logic [15:0] crc_o
);
  import prs_pkg::*;
  logic [15:0] crc_q, base;

  assign base = clr_i ? 16'h0000 : crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= '0;
    else if (upd_i) crc_q <= crc16_byte(base, din_i);
    else            crc_q <= base;
  end

  assign crc_o = crc_q;

  AST_CRC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!clr_i && !upd_i)) |-> $stable(crc_q)); // R4
endmodule

// File: rtl/prs_store.sv
module prs_store #(
  parameter int N_PAGES    = 64,
  parameter int PAGE_BYTES = 32,
  localparam int PG_W = $clog2(N_PAGES),
  localparam int AW   = PG_W + $clog2(PAGE_BYTES)
) (
  input  logic            clk_i,
  input  logic            ld_en_i,
  input  logic            ld_sel_i,
  input  logic [AW-1:0]   ld_addr_i,
  input  logic [7:0]      ld_data_i,
  input  logic [AW-1:0]   rd_addr_i,
  input  logic [PG_W-1:0] rd_page_i,
  output logic [7:0]      rd_data_o,
  output logic [7:0]      rd_rdir_o
);
  logic [7:0] mem_q  [N_PAGES*PAGE_BYTES];
  logic [7:0] rdir_q [N_PAGES];

  always_ff @(posedge clk_i) begin
    if (ld_en_i && !ld_sel_i) mem_q[ld_addr_i] <= ld_data_i;
    if (ld_en_i &&  ld_sel_i) rdir_q[ld_addr_i[PG_W-1:0]] <= ld_data_i;
  end

  assign rd_data_o = mem_q[rd_addr_i];
  assign rd_rdir_o = rdir_q[rd_page_i];
endmodule

// File: rtl/prs_seq.sv
module prs_seq #(
  parameter int PG_W  = 6,
  parameter int OFS_W = 5,
  localparam int AW   = PG_W + OFS_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            abort_i,
  input  logic            cmd_valid_i,
  input  logic [7:0]      cmd_byte_i,
  input  logic            rd_req_i,
  input  logic [7:0]      mem_i,
  input  logic [7:0]      rdir_i,
  input  logic [15:0]     crc_i,
  output logic [AW-1:0]   addr_o,
  output logic            crc_clr_o,
  output logic            crc_upd_o,
  output logic [7:0]      crc_din_o,
  output logic            rsp_valid_o,
  output logic [7:0]      rsp_byte_o
);
  import prs_pkg::*;

  seq_st_e       st_q;
  logic [7:0]    al_q;
  logic [AW-1:0] addr_q;
  logic          rsp_valid_q;
  logic [7:0]    rsp_byte_q;
  logic [7:0]    tx_byte;
  logic          in_rsp, take;
  logic [15:0]   full_addr;

  assign in_rsp    = (st_q inside {ST_RDIR, ST_RCRC_L, ST_RCRC_H, ST_DATA,
                                   ST_DCRC_L, ST_DCRC_H, ST_DONE});
  assign take      = in_rsp && rd_req_i;
  assign full_addr = {cmd_byte_i, al_q};

  always_comb begin
    unique case (st_q)
      ST_RDIR:              tx_byte = rdir_i;
      ST_RCRC_L, ST_DCRC_L: tx_byte = ~crc_i[7:0];
      ST_RCRC_H, ST_DCRC_H: tx_byte = ~crc_i[15:8];
      ST_DATA:              tx_byte = mem_i;
      default:              tx_byte = 8'hFF;
    endcase
  end

  always_comb begin
    crc_clr_o = 1'b0;
    crc_upd_o = 1'b0;
    crc_din_o = cmd_byte_i;
    if (!abort_i) begin
      unique case (st_q)
        ST_CMD: begin
          crc_clr_o = cmd_valid_i && cmd_byte_i == CMD_XREAD;
          crc_upd_o = crc_clr_o;
        end
        ST_AL, ST_AH: crc_upd_o = cmd_valid_i;
        ST_RDIR: begin
          crc_upd_o = rd_req_i;
          crc_din_o = rdir_i;
        end
        ST_DATA: begin
          crc_upd_o = rd_req_i;
          crc_din_o = mem_i;
        end
        ST_RCRC_H, ST_DCRC_H: crc_clr_o = rd_req_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_CMD;
      al_q        <= '0;
      addr_q      <= '0;
      rsp_valid_q <= 1'b0;
      rsp_byte_q  <= 8'hFF;
    end else if (abort_i) begin
      st_q        <= ST_CMD;
      rsp_valid_q <= 1'b0;
    end else begin
      rsp_valid_q <= take;
      if (take) rsp_byte_q <= tx_byte;
      unique case (st_q)
        ST_CMD: if (cmd_valid_i && cmd_byte_i == CMD_XREAD) st_q <= ST_AL;
        ST_AL: if (cmd_valid_i) begin
          al_q <= cmd_byte_i;
          st_q <= ST_AH;
        end
        ST_AH: if (cmd_valid_i) begin
          addr_q <= full_addr[AW-1:0];
          st_q   <= ST_RDIR;
        end
        ST_RDIR:   if (rd_req_i) st_q <= ST_RCRC_L;
        ST_RCRC_L: if (rd_req_i) st_q <= ST_RCRC_H;
        ST_RCRC_H: if (rd_req_i) st_q <= ST_DATA;
        ST_DATA: if (rd_req_i) begin
          addr_q <= addr_q + 1'b1;
          if (&addr_q[OFS_W-1:0]) st_q <= ST_DCRC_L;
        end
        ST_DCRC_L: if (rd_req_i) st_q <= ST_DCRC_H;
        ST_DCRC_H: if (rd_req_i) st_q <= (addr_q == '0) ? ST_DONE : ST_RDIR;
        default: ;
      endcase
    end
  end

  assign addr_o      = addr_q;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_byte_o  = rsp_byte_q;

  AST_RSP_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_q |-> $past(rd_req_i)); // R9
  AST_DONE_ALL_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(st_q) == ST_DONE && rsp_valid_q) |-> rsp_byte_q == 8'hFF); // R7
  AST_PAGE_CRC_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(st_q) == ST_DCRC_H && st_q == ST_RDIR) |-> crc_i == 16'h0000); // R6
  AST_PAGE_END_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(st_q) == ST_DATA && st_q == ST_DCRC_L) |-> addr_q[OFS_W-1:0] == '0); // R5
  AST_ABORT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(abort_i) |-> (st_q == ST_CMD && !rsp_valid_q)); // R1
endmodule

// File: rtl/paged_redirect_reader.sv
module paged_redirect_reader #(
  parameter int N_PAGES    = 64,
  parameter int PAGE_BYTES = 32,
  localparam int PG_W  = $clog2(N_PAGES),
  localparam int OFS_W = $clog2(PAGE_BYTES),
  localparam int AW    = PG_W + OFS_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          abort_i,
  input  logic          cmd_valid_i,
  input  logic [7:0]    cmd_byte_i,
  input  logic          rd_req_i,
  output logic          rsp_valid_o,
  output logic [7:0]    rsp_byte_o,
  input  logic          ld_en_i,
  input  logic          ld_sel_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic [7:0]    ld_data_i
);
  logic [AW-1:0] addr;
  logic [7:0]    mem_b, rdir_b, crc_din;
  logic          crc_clr, crc_upd;
  logic [15:0]   crc;

  prs_store #(.N_PAGES(N_PAGES), .PAGE_BYTES(PAGE_BYTES)) u_store (
    .clk_i, .ld_en_i, .ld_sel_i, .ld_addr_i, .ld_data_i,
    .rd_addr_i(addr), .rd_page_i(addr[AW-1:OFS_W]),
    .rd_data_o(mem_b), .rd_rdir_o(rdir_b)
  );

  prs_crc16 u_crc (
    .clk_i, .rst_ni, .clr_i(crc_clr), .upd_i(crc_upd), .din_i(crc_din), .crc_o(crc)
  );

  prs_seq #(.PG_W(PG_W), .OFS_W(OFS_W)) u_seq (
    .clk_i, .rst_ni, .abort_i, .cmd_valid_i, .cmd_byte_i, .rd_req_i,
    .mem_i(mem_b), .rdir_i(rdir_b), .crc_i(crc), .addr_o(addr),
    .crc_clr_o(crc_clr), .crc_upd_o(crc_upd), .crc_din_o(crc_din),
    .rsp_valid_o, .rsp_byte_o
  );
endmodule

// File: tb/sim_paged_redirect_reader.sv
module sim_paged_redirect_reader;
  logic clk = 0, rst_ni = 0, abort_i = 0, cmd_valid_i = 0, rd_req_i = 0;
  logic [7:0] cmd_byte_i = 0, ld_data_i = 0, rsp_byte_o;
  logic rsp_valid_o, ld_en_i = 0, ld_sel_i = 0;
  logic [10:0] ld_addr_i = 0;
  int checks = 0, errors = 0;

  logic [7:0] m_mem [2048];
  logic [7:0] m_rd  [64];
  logic [7:0] exp_b [512];
  string      exp_t [512];

  always #10 clk = ~clk;

  paged_redirect_reader u0 (.clk_i(clk), .*);

  function automatic logic [15:0] c16(input logic [15:0] c, input logic [7:0] b);
    for (int i = 0; i < 8; i++) c = (c[0] ^ b[i]) ? ((c >> 1) ^ 16'hA001) : (c >> 1);
    return c;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load(input bit sel, input int a, input logic [7:0] d);
    @(negedge clk);
    ld_en_i = 1; ld_sel_i = sel; ld_addr_i = a[10:0]; ld_data_i = d;
    if (sel) m_rd[a[5:0]] = d; else m_mem[a] = d;
    @(negedge clk);
    ld_en_i = 0;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    cmd_valid_i = 1; cmd_byte_i = b;
    @(negedge clk);
    cmd_valid_i = 0;
  endtask

  task automatic pull(output logic v, output logic [7:0] b);
    @(negedge clk);
    rd_req_i = 1;
    @(negedge clk);
    rd_req_i = 0;
    v = rsp_valid_o; b = rsp_byte_o;
  endtask

  // model of the response stream; first pass R4, later passes R6
  task automatic build(input logic [7:0] al, input logic [7:0] ah, input int n);
    logic [15:0] c;
    int a, k;
    bit first;
    c = c16(c16(c16(16'h0, 8'hA5), al), ah);
    a = {ah[2:0], al};
    first = 1; k = 0;
    while (k < n && a < 2048) begin
      exp_b[k] = m_rd[a/32]; exp_t[k] = first ? "R4 redir" : "R8 redir"; k++;
      c = first ? c16(c, m_rd[a/32]) : c16(16'h0, m_rd[a/32]);
      exp_b[k] = ~c[7:0];  exp_t[k] = first ? "R4 crc lo" : "R6 crc lo"; k++;
      exp_b[k] = ~c[15:8]; exp_t[k] = first ? "R4 crc hi" : "R6 crc hi"; k++;
      c = 0;
      do begin
        exp_b[k] = m_mem[a]; exp_t[k] = first ? "R5 data" : "R6 data"; k++;
        c = c16(c, m_mem[a]); a++;
      end while (a % 32 != 0);
      exp_b[k] = ~c[7:0];  exp_t[k] = "R5 dcrc lo"; k++;
      exp_b[k] = ~c[15:8]; exp_t[k] = "R5 dcrc hi"; k++;
      c = 0; first = 0;
    end
    while (k < n) begin exp_b[k] = 8'hFF; exp_t[k] = "R7 tail"; k++; end
  endtask

  task automatic run(input logic [7:0] al, input logic [7:0] ah, input int n);
    logic v; logic [7:0] b;
    build(al, ah, n);
    send(8'hA5); send(al); send(ah);
    for (int k = 0; k < n; k++) begin
      pull(v, b);
      chk(v === 1'b1 && b === exp_b[k], {exp_t[k], " R9"}, {v, b}, {1'b1, exp_b[k]});
    end
  endtask

  task automatic t_reset;
    logic v; logic [7:0] b;
    chk(rsp_valid_o === 1'b0, "R1 reset valid", rsp_valid_o, 0);
    pull(v, b);
    chk(v === 1'b0, "R9 req while idle", v, 0);
  endtask

  task automatic t_bad_cmd;
    logic v; logic [7:0] b;
    send(8'h0F);
    pull(v, b);
    chk(v === 1'b0, "R2 bad cmd no rsp", v, 0);
    send(8'hF0);
    run(8'h40, 8'h00, 8);  // R2: CRC proves bad bytes left no trace
  endtask

  task automatic t_tail_masked;
    abort_i = 1; @(negedge clk); abort_i = 0;
    // R3: high byte FF masked to 7 -> start 0x7DE, page 62 redirected
    run(8'hDE, 8'hFF, 3 + 2 + 2 + 37 + 5);
  endtask

  task automatic t_full_pages;
    logic v; logic [7:0] b;
    abort_i = 1; @(negedge clk); abort_i = 0;
    run(8'h00, 8'h00, 37 + 37 + 10);
    @(negedge clk); abort_i = 1; @(negedge clk); abort_i = 0;
    chk(rsp_valid_o === 1'b0, "R1 abort valid", rsp_valid_o, 0);
    pull(v, b);
    chk(v === 1'b0, "R1 no rsp after abort", v, 0);
  endtask

  task automatic t_abort_addr;
    send(8'hA5); send(8'h77);
    @(negedge clk); abort_i = 1; @(negedge clk); abort_i = 0;
    run(8'h25, 8'h01, 6);  // R1: old low byte discarded
  endtask

  task automatic t_load;
    load(1'b0, 16'h0123, 8'h3C);
    load(1'b1, 9, 8'hF6);
    abort_i = 1; @(negedge clk); abort_i = 0;
    run(8'h23, 8'h01, 6);  // R10
  endtask

  initial begin
    for (int a = 0; a < 2048; a++) m_mem[a] = 8'((a * 37 + 5) ^ (a >> 8));
    for (int p = 0; p < 64; p++)   m_rd[p] = 8'hFF;
    m_rd[62] = ~8'd3;
    m_rd[1]  = ~8'd40;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    for (int a = 0; a < 2048; a++) load(1'b0, a, m_mem[a]);
    for (int p = 0; p < 64; p++)   load(1'b1, p, m_rd[p]);
    t_reset();
    t_bad_cmd();
    t_tail_masked();
    t_full_pages();
    t_abort_addr();
    t_load();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #3_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule